// File: doc/BRIEF.md
# SPI Memory Slave Command Front-End

This block is the serial front end of a small memory device. It runs as an SPI slave in mode 0: SI is sampled on rising SCK, SO changes on falling SCK, and bytes travel MSB first. Each frame opens with a single-byte instruction. Five instructions exist:

- WRITE (0x02) stores bytes.
- READ (0x03) returns bytes.
- WRDI (0x04) clears the write-enable flag.
- RDSR (0x05) returns the status byte.
- WREN (0x06) sets the write-enable flag.

READ and WRITE carry a 16-bit big-endian address after the instruction. The address then steps forward once per further byte while CS stays low.

Three regions are decoded:

- A 256-byte data array at 0x0000 to 0x00FF. Writes to it need the write-enable flag.
- A 64-byte command buffer at 0xFE00 to 0xFE3F. It accepts writes with no write-enable and is presented in parallel on `cmdBuf` for a downstream command engine.
- A one-byte response register at 0xFE00. It holds the last error code and is the only readable location outside the data array.

A bad instruction or a bad address sets a sticky error flag and records an error code. The block then keeps SO released for the rest of the frame.

The serial inputs are brought into the system clock domain, and all state runs on that clock. `soEn` is the output enable for an external tri-state pad driving `so`.

Top module: `spiMemFront`

## Requirements
- R1: READ (0x03) with a valid address returns the addressed bytes MSB first. The first bit is valid after the falling SCK that follows the last address bit. Reading the data array steps the address and wraps from 0x00FF to 0x0000.
- R2: WREN (0x06) sets the write-enable flag, reported as status bit 1. `soEn` stays low for the whole WREN frame.
- R3: WRDI (0x04) clears the write-enable flag.
- R4: After reset, `soEn` is low, the status byte is 0x00 and `cmdBuf` is all zero. A WRITE to the data array while write-enable is clear leaves the array unchanged and raises no error.
- R5: With write-enable set, WRITE stores each data byte at the running address, wrapping inside the data array. Write-enable clears when CS rises after a frame that stored at least one data-array byte.
- R6: A WRITE into 0xFE00 to 0xFE3F is stored regardless of write-enable and wraps inside that range. Byte i of the buffer appears on `cmdBuf[8*i+7:8*i]`. Such a write does not change write-enable.
- R7: An instruction byte other than 0x02 to 0x06 does three things. It keeps `soEn` low for the rest of the frame. It sets the error flag (status bit 2), which stays set. It records error code 0x01.
- R8: An invalid address has the same effect as R7, except that the error code recorded is 0x02. Valid READ addresses are 0x0000 to 0x00FF and 0xFE00. Valid WRITE addresses are 0x0000 to 0x00FF and 0xFE00 to 0xFE3F.
- R9: READ at 0xFE00 returns the stored error code. It changes neither the error code nor the status byte.
- R10: A byte cut short by CS rising has no effect. A frame that was only partly received leaves state as it was after the last complete byte.
- R11: RDSR (0x05) returns the status byte {5'b0, error, write-enable, 1'b0}. It repeats that byte for as long as CS stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| csN | input | 1 | SPI chip select, active low |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| soEn | output | 1 | High when `so` should be driven onto the pad |
| cmdBuf | output | 512 | Command buffer contents, byte i at bits 8*i+7 to 8*i |

## Verification
The hardest case to reach is the partial frame. In it, CS rises a few SCK periods into a byte while data-array writes or a write-enable change are pending. The bench ends such frames mid-instruction and mid-data-byte. Status and read-back frames that follow then show that nothing beyond the last complete byte took effect.

Wrap-around is also exercised. Writes start near the ends of both the data array and the command buffer, so the running address has to wrap. A readback then confirms each wrapped byte.

The error paths are driven by three kinds of frame: an undefined instruction byte, a data-range address above 0x00FF, and a command-range address above 0xFE3F. Each is followed by reads of the response register and of the status byte. These reads confirm that reading the response register changes neither value.

// File: rtl/spiMemPkg.sv
package spiMemPkg;

  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  localparam logic [7:0] ERR_OPCODE = 8'h01;
  localparam logic [7:0] ERR_ADDR   = 8'h02;

  typedef enum logic [2:0] {
    S_OPC,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_RDAT,
    S_STAT,
    S_IDLE
  } feState_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic        memWr;
    logic        cmdWr;
    logic        setWel;
    logic        clrWel;
    logic        setErr;
    logic [7:0]  errCode;
    logic [15:0] addr;
    logic [7:0]  data;
  } feStrobe_t;

endpackage

// File: rtl/spiMemData.sv
module spiMemData
  import spiMemPkg::*;
#(
  parameter int DATA_BYTES = 256,
  parameter int CMD_BYTES  = 64,
  parameter logic [15:0] CMD_BASE = 16'hFE00
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  feStrobe_t              st,
  input  logic [15:0]            rdAddr,
  output logic [7:0]             rdByte,
  output logic [7:0]             statusByte,
  output logic [CMD_BYTES*8-1:0] cmdBufOut
);

  localparam int DATA_AW = $clog2(DATA_BYTES);
  localparam int CMD_AW  = $clog2(CMD_BYTES);
  localparam logic [15:0] DATA_LIM = 16'(DATA_BYTES);

  logic [7:0] memArr [DATA_BYTES];
  logic [7:0] cmdArr [CMD_BYTES];
  logic       wel;
  logic       eerr;
  logic [7:0] errCode;
  logic [15:0] cmdOff;

  assign cmdOff = st.addr - CMD_BASE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DATA_BYTES; i++) memArr[i] <= '0;
      for (int i = 0; i < CMD_BYTES; i++) cmdArr[i] <= '0;
      wel     <= 1'b0;
      eerr    <= 1'b0;
      errCode <= '0;
    end else begin
      if (st.memWr && st.addr < DATA_LIM) memArr[DATA_AW'(st.addr)] <= st.data;
      if (st.cmdWr) cmdArr[CMD_AW'(cmdOff)] <= st.data;
      if (st.setWel) wel <= 1'b1;
      else if (st.clrWel) wel <= 1'b0;
      if (st.setErr) begin
        eerr    <= 1'b1;
        errCode <= st.errCode;
      end
    end
  end

  assign rdByte     = (rdAddr < DATA_LIM) ? memArr[DATA_AW'(rdAddr)] : errCode;
  assign statusByte = {5'b0, eerr, wel, 1'b0};

  for (genvar g = 0; g < CMD_BYTES; g++) begin : gCmdOut
    assign cmdBufOut[g*8 +: 8] = cmdArr[g];
  end

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.setWel |=> wel);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    eerr |=> eerr);

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.setErr |=> $stable(errCode));

  // R6
  cmd_keeps_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.cmdWr && !st.setWel && !st.clrWel) |=> $stable(wel));

endmodule

// File: rtl/spiMemCtrl.sv
module spiMemCtrl
  import spiMemPkg::*;
#(
  parameter int DATA_BYTES = 256,
  parameter int CMD_BYTES  = 64,
  parameter logic [15:0] CMD_BASE = 16'hFE00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sck,
  input  logic        csN,
  input  logic        si,
  input  logic [7:0]  rdByte,
  input  logic [7:0]  statusByte,
  output feStrobe_t   st,
  output logic [15:0] rdAddr,
  output logic        so,
  output logic        soEn
);

  localparam logic [15:0] DATA_LIM  = 16'(DATA_BYTES);
  localparam logic [15:0] DATA_MASK = DATA_LIM - 16'd1;
  localparam logic [15:0] CMD_MASK  = 16'(CMD_BYTES) - 16'd1;
  localparam logic [15:0] CMD_END   = CMD_BASE + 16'(CMD_BYTES);

  logic [2:0] sckSh, csSh;
  logic [1:0] siSh;
  logic       sckRise, sckFall, csActive, csRise;
  logic       siBit;

  feState_e   state;
  logic [2:0] bitCnt;
  logic [6:0] shiftIn;
  logic [7:0] addrHi;
  logic [15:0] addr;
  logic [7:0] outBuf;
  logic       soReg;
  logic       loadReq, loadStat, isWrite, dataWritten;

  logic [7:0]  byteIn;
  logic        byteDone;
  logic [15:0] fullAddr, addrInc, nextAddr;
  logic        inData, inCmd, fullOk, opValid;
  logic        wel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh <= '0;
      csSh  <= '1;
      siSh  <= '0;
    end else begin
      sckSh <= {sckSh[1:0], sck};
      csSh  <= {csSh[1:0], csN};
      siSh  <= {siSh[0], si};
    end
  end

  assign sckRise  = sckSh[1] & ~sckSh[2];
  assign sckFall  = ~sckSh[1] & sckSh[2];
  assign csActive = ~csSh[1];
  assign csRise   = csSh[1] & ~csSh[2];
  assign siBit    = siSh[1];
  assign wel      = statusByte[1];

  assign byteIn   = {shiftIn, siBit};
  assign byteDone = csActive & sckRise & (bitCnt == 3'd7);
  assign fullAddr = {addrHi, byteIn};
  assign addrInc  = addr + 16'd1;
  assign inData   = addr < DATA_LIM;
  assign inCmd    = (addr >= CMD_BASE) && (addr < CMD_END);
  assign opValid  = (byteIn >= OP_WRITE) && (byteIn <= OP_WREN);

  always_comb begin
    if (fullAddr < DATA_LIM) fullOk = 1'b1;
    else if (isWrite)        fullOk = (fullAddr >= CMD_BASE) && (fullAddr < CMD_END);
    else                     fullOk = (fullAddr == CMD_BASE);
  end

  always_comb begin
    if (inData)       nextAddr = addrInc & DATA_MASK;
    else if (isWrite) nextAddr = CMD_BASE | (addrInc & CMD_MASK);
    else              nextAddr = addr;
  end

  always_comb begin
    st      = '0;
    st.addr = addr;
    st.data = byteIn;
    if (byteDone) begin
      case (state)
        S_OPC: begin
          if (byteIn == OP_WREN) st.setWel = 1'b1;
          if (byteIn == OP_WRDI) st.clrWel = 1'b1;
          if (!opValid) begin
            st.setErr  = 1'b1;
            st.errCode = ERR_OPCODE;
          end
        end
        S_ALO: if (!fullOk) begin
          st.setErr  = 1'b1;
          st.errCode = ERR_ADDR;
        end
        S_WDAT: begin
          st.memWr = inData & wel;
          st.cmdWr = inCmd;
        end
        default: ;
      endcase
    end
    if (csRise && dataWritten) st.clrWel = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_OPC;
      bitCnt      <= '0;
      shiftIn     <= '0;
      addrHi      <= '0;
      addr        <= '0;
      outBuf      <= '0;
      soReg       <= 1'b0;
      loadReq     <= 1'b0;
      loadStat    <= 1'b0;
      isWrite     <= 1'b0;
      dataWritten <= 1'b0;
    end else begin
      loadReq <= 1'b0;
      if (loadReq) outBuf <= loadStat ? statusByte : rdByte;
      if (!csActive) begin
        state       <= S_OPC;
        bitCnt      <= '0;
        dataWritten <= 1'b0;
      end else if (sckFall) begin
        soReg <= outBuf[~bitCnt];
      end else if (sckRise) begin
        shiftIn <= byteIn[6:0];
        bitCnt  <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          case (state)
            S_OPC: begin
              if (byteIn == OP_WRITE || byteIn == OP_READ) begin
                isWrite <= (byteIn == OP_WRITE);
                state   <= S_AHI;
              end else if (byteIn == OP_RDSR) begin
                state    <= S_STAT;
                loadReq  <= 1'b1;
                loadStat <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
            S_AHI: begin
              addrHi <= byteIn;
              state  <= S_ALO;
            end
            S_ALO: begin
              addr <= fullAddr;
              if (!fullOk)     state <= S_IDLE;
              else if (isWrite) state <= S_WDAT;
              else begin
                state    <= S_RDAT;
                loadReq  <= 1'b1;
                loadStat <= 1'b0;
              end
            end
            S_WDAT: begin
              addr <= nextAddr;
              if (st.memWr) dataWritten <= 1'b1;
            end
            S_RDAT: begin
              addr    <= nextAddr;
              loadReq <= 1'b1;
            end
            S_STAT: loadReq <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assign rdAddr = addr;
  assign so     = soReg;
  assign soEn   = csActive & ((state == S_RDAT) | (state == S_STAT));

  // R7
  err_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.setErr |=> !soEn);

  // R10
  cs_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> (bitCnt == 3'd0 && state == S_OPC));

  // R5
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.memWr |=> dataWritten);

endmodule

// File: rtl/spiMemFront.sv
module spiMemFront
  import spiMemPkg::*;
#(
  parameter int DATA_BYTES = 256,
  parameter int CMD_BYTES  = 64,
  parameter logic [15:0] CMD_BASE = 16'hFE00
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sck,
  input  logic                   csN,
  input  logic                   si,
  output logic                   so,
  output logic                   soEn,
  output logic [CMD_BYTES*8-1:0] cmdBuf
);

  feStrobe_t   strobes;
  logic [15:0] rdAddr;
  logic [7:0]  rdByte;
  logic [7:0]  statusByte;

  spiMemCtrl #(
    .DATA_BYTES(DATA_BYTES), .CMD_BYTES(CMD_BYTES), .CMD_BASE(CMD_BASE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si),
    .rdByte(rdByte), .statusByte(statusByte), .st(strobes),
    .rdAddr(rdAddr), .so(so), .soEn(soEn)
  );

  spiMemData #(
    .DATA_BYTES(DATA_BYTES), .CMD_BYTES(CMD_BYTES), .CMD_BASE(CMD_BASE)
  ) uData (
    .clk(clk), .rstN(rstN), .st(strobes), .rdAddr(rdAddr),
    .rdByte(rdByte), .statusByte(statusByte), .cmdBufOut(cmdBuf)
  );

endmodule

// File: tb/sim_spiMemFront.sv
`timescale 1ns/1ps
module sim_spiMemFront;

  logic clk = 1'b0;
  logic rstN, sck, csN, si;
  logic so, soEn;
  logic [511:0] cmdBuf;

  always #2 clk = ~clk;

  spiMemFront u0 (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si),
    .so(so), .soEn(soEn), .cmdBuf(cmdBuf)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0] mMem [256];
  logic [7:0] mCmd [64];
  bit         mWel, mErr;
  logic [7:0] mCode;
  logic [7:0] txQ [$];

  function automatic logic [7:0] mStatus();
    return {5'b0, mErr, mWel, 1'b0};
  endfunction

  function automatic logic [7:0] mRead(logic [15:0] a);
    return (a < 16'h0100) ? mMem[a[7:0]] : mCode;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // one CS frame; lastBits < 8 truncates the final byte
  task automatic frame(input string tag, input int lastBits);
    int mode = 0;
    bit wr = 0, wrote = 0, en;
    logic [15:0] a = '0;
    logic [7:0] ob = '0, ahi = '0, b;
    csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < txQ.size(); k++) begin
      int nb = (k == txQ.size() - 1) ? lastBits : 8;
      b  = txQ[k];
      en = (mode == 4 || mode == 5);
      for (int i = 0; i < nb; i++) begin
        si = b[7-i];
        repeat (8) @(negedge clk);
        chk(soEn == en, tag, "soEn", soEn, en);
        if (en) chk(so == ob[7-i], tag, "so bit", so, ob[7-i]);
        sck = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
      end
      if (nb == 8) begin
        case (mode)
          0: begin
            if (b == 8'h02 || b == 8'h03) begin wr = (b == 8'h02); mode = 1; end
            else if (b == 8'h04) begin mWel = 0; mode = 6; end
            else if (b == 8'h05) begin ob = mStatus(); mode = 5; end
            else if (b == 8'h06) begin mWel = 1; mode = 6; end
            else begin mErr = 1; mCode = 8'h01; mode = 6; end
          end
          1: begin ahi = b; mode = 2; end
          2: begin
            bit ok;
            a  = {ahi, b};
            ok = (a < 16'h0100) ||
                 (wr ? (a >= 16'hFE00 && a < 16'hFE40) : (a == 16'hFE00));
            if (!ok) begin mErr = 1; mCode = 8'h02; mode = 6; end
            else if (wr) mode = 3;
            else begin mode = 4; ob = mRead(a); end
          end
          3: begin
            if (a < 16'h0100) begin
              if (mWel) begin mMem[a[7:0]] = b; wrote = 1; end
              a = {8'h00, a[7:0] + 8'd1};
            end else begin
              mCmd[a[5:0]] = b;
              a = {10'b1111_1110_00, a[5:0] + 6'd1};
            end
          end
          4: begin
            if (a < 16'h0100) a = {8'h00, a[7:0] + 8'd1};
            ob = mRead(a);
          end
          5: ob = mStatus();
          default: ;
        endcase
      end
    end
    repeat (8) @(negedge clk);
    csN = 1'b1;
    if (wrote) mWel = 0;
    repeat (8) @(negedge clk);
    begin
      bit same = 1;
      for (int j = 0; j < 64; j++) if (cmdBuf[j*8 +: 8] !== mCmd[j]) same = 0;
      chk(same, tag, "cmdBuf", cmdBuf[31:0], {mCmd[3], mCmd[2], mCmd[1], mCmd[0]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=expired exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    for (int i = 0; i < 256; i++) mMem[i] = '0;
    for (int i = 0; i < 64; i++) mCmd[i] = '0;
    mWel = 0; mErr = 0; mCode = '0;
    rstN = 1'b0; sck = 1'b0; csN = 1'b1; si = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R4 reset state
    chk(soEn == 1'b0, "R4", "reset soEn", soEn, 0);
    chk(cmdBuf == '0, "R4", "reset cmdBuf", cmdBuf[31:0], 0);
    txQ = {8'h05, 8'h00, 8'h00}; frame("R11", 8);

    // R4 write without write-enable is dropped
    txQ = {8'h02, 8'h00, 8'h10, 8'hAA}; frame("R4", 8);
    txQ = {8'h03, 8'h00, 8'h10, 8'h00}; frame("R1", 8);

    // R2 set write-enable, R11 status shows it
    txQ = {8'h06, 8'h00}; frame("R2", 8);
    txQ = {8'h05, 8'h00, 8'h00, 8'h00}; frame("R11", 8);

    // R5 store with wrap, then write-enable drops
    txQ = {8'h02, 8'h00, 8'hFE, 8'h11, 8'h22, 8'h33}; frame("R5", 8);
    txQ = {8'h05, 8'h00}; frame("R5", 8);
    txQ = {8'h03, 8'h00, 8'hFE, 8'h00, 8'h00, 8'h00}; frame("R1", 8);

    // R6 command buffer ignores write-enable, wraps in range
    txQ = {8'h02, 8'hFE, 8'h3E, 8'h05, 8'h06, 8'h07}; frame("R6", 8);
    txQ = {8'h06}; frame("R2", 8);
    txQ = {8'h02, 8'hFE, 8'h01, 8'h99}; frame("R6", 8);
    txQ = {8'h05, 8'h00}; frame("R6", 8);

    // R3 clear write-enable
    txQ = {8'h04}; frame("R3", 8);
    txQ = {8'h05, 8'h00}; frame("R3", 8);

    // R7 bad instruction
    txQ = {8'h07, 8'h03, 8'h00}; frame("R7", 8);
    txQ = {8'h05, 8'h00}; frame("R7", 8);
    txQ = {8'h03, 8'hFE, 8'h00, 8'h00, 8'h00}; frame("R9", 8);
    txQ = {8'h05, 8'h00}; frame("R9", 8);

    // R8 bad addresses
    txQ = {8'h03, 8'h01, 8'h00, 8'h00}; frame("R8", 8);
    txQ = {8'h03, 8'hFE, 8'h00, 8'h00}; frame("R8", 8);
    txQ = {8'h02, 8'hFE, 8'h40, 8'h12}; frame("R8", 8);
    txQ = {8'h03, 8'hFE, 8'h01, 8'h00}; frame("R8", 8);
    txQ = {8'h03, 8'hFE, 8'h00, 8'h00}; frame("R9", 8);

    // R10 truncated frames
    txQ = {8'h06}; frame("R10", 3);
    txQ = {8'h05, 8'h00}; frame("R10", 8);
    txQ = {8'h06}; frame("R2", 8);
    txQ = {8'h02, 8'h00, 8'h20, 8'h55, 8'h77}; frame("R10", 5);
    txQ = {8'h03, 8'h00, 8'h20, 8'h00, 8'h00}; frame("R10", 8);
    txQ = {8'h05, 8'h00}; frame("R10", 8);

    // R5 / R1 varied data patterns
    lfsr = 8'h5B;
    txQ = {8'h06}; frame("R2", 8);
    txQ = {8'h02, 8'h00, 8'h40};
    for (int i = 0; i < 8; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      txQ.push_back(lfsr);
    end
    frame("R5", 8);
    txQ = {8'h03, 8'h00, 8'h40};
    for (int i = 0; i < 9; i++) txQ.push_back(8'h00);
    frame("R1", 8);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule